// File: doc/BRIEF.md
# I2C Command and Register Slave

This block is the serial control front end of a message-storage controller. It watches the SCL and SDA lines and finds START and STOP conditions in its own clock domain. It responds to one 7-bit slave address: the fixed upper bits `10000` followed by two strap inputs, so four of these devices can share one bus. A write transaction carries one command byte. Depending on the command, two data bytes may follow and load one of three 16-bit registers: configuration word 0, configuration word 1, or the page/block storage address.

Each command byte is split into four fields:

- a power bit (bit 7),
- a digital/analog select bit (bit 6),
- a 3-bit function code (bits 5:3),
- a 3-bit register-select code (bits 2:0).

Once the command byte has been received, plus its data bytes when it has any, the block raises exactly one decoded strobe for one cycle. The strobes cover power control, analog record and playback, entering and leaving digital mode, and erasing, writing and reading digital pages. The storage array and the audio paths sit behind these strobes.

A read transaction returns three bytes in order: a status byte, the high address byte, and the low address byte. The status byte holds the pending-interrupt flag and seven status inputs. Reading the status byte clears the pending interrupt. The block never stretches the clock.

Top module: `i2cs_cmd_slave`

## Requirements
- R1: The block acknowledges only the address byte `{5'b10000, strap_i[1:0], rw}`, where rw=0 means write and rw=1 means read. It leaves SDA released during the acknowledge bit of any other address and ignores the rest of that transaction.
- R2: A command byte is decoded as power=bit7, digital=bit6, function=bits5:3, select=bits2:0. Each command raises one `cmd_stb` bit:
  - power=1, digital=0, function=000: bit 0 (power up / stop)
  - power=0, digital=0, function=000: bit 1 (power down)
  - digital=0, function=010: bit 2 (record)
  - digital=0, function=001: bit 3 (playback)
  - power=1, digital=1, function=000: bit 4 (enter digital mode)
  - power=0, digital=1, function=000: bit 5 (exit digital mode)
  - digital=1, function=010: bit 6 (erase page)
  - digital=1, function=001: bit 7 (write digital)
  - digital=1, function=100: bit 8 (read digital)
  - Any other combination raises no strobe.
- R3: Select 010 loads the next two bytes into `cfg0_o`, and select 011 loads them into `cfg1_o`. The first byte is the most significant.
- R4: Select 001 loads the next two bytes, high byte first, into the address register. Bits 15:5 of that word appear on `page_o` and bits 4:0 on `block_o`.
- R5: A command with select 001, 010 or 011 raises its strobe only after its second data byte, in the same step as the register update. Any other command raises its strobe right after the command byte.
- R6: A select code with bit 2 set is acknowledged but changes no register.
- R7: A STOP or a repeated START before the second data byte discards the partial command: no register changes and no strobe is raised.
- R8: A read returns the status byte `{irq, stat_i[6:0]}`, then the address high byte, then the address low byte, then 00h for any further byte.
- R9: `evt_i` sets the pending interrupt `irq_o`. Sending the status byte clears it. An event in the same cycle as the clear wins.
- R10: After a matched address, every written byte is acknowledged. A read ends on the master's NACK with SDA released.
- R11: After reset, all registers are zero, `irq_o` is low and SDA is released.
- R12: At most one `cmd_stb` bit is high in any cycle, and each strobe lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | High pulls SDA low |
| strap_i | input | 2 | Low two bits of the slave address |
| stat_i | input | 7 | Status flags returned in the status byte |
| evt_i | input | 1 | Interrupt event (end of message or overflow) |
| cmd_stb | output | 9 | One-cycle decoded command strobes |
| cfg0_o | output | 16 | Configuration word 0 |
| cfg1_o | output | 16 | Configuration word 1 |
| page_o | output | 11 | Page number of the address register |
| block_o | output | 5 | Block number of the address register |
| irq_o | output | 1 | Pending interrupt |

## Verification
Two functions can fall in the same cycle: an interrupt event can arrive in the cycle the status byte is loaded for sending, which clears the pending flag. The bench provokes this by holding `evt_i` high across the whole read address phase. It then judges by the flag itself, which must stay set, and by the status byte of a second read, which must still show bit 7 set before the flag finally clears. A related case is a register load cut short by a repeated START. Here the discard and the new command's acceptance follow each other closely, and the bench checks that only the second command takes effect.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

  localparam int BYTE_W = 8;
  localparam int STB_N  = 9;

  localparam int STB_PWR_UP  = 0;
  localparam int STB_PWR_DN  = 1;
  localparam int STB_REC     = 2;
  localparam int STB_PLAY    = 3;
  localparam int STB_DIG_IN  = 4;
  localparam int STB_DIG_OUT = 5;
  localparam int STB_ERASE   = 6;
  localparam int STB_DWRITE  = 7;
  localparam int STB_DREAD   = 8;

  localparam logic [2:0] SEL_ADDR = 3'b001;
  localparam logic [2:0] SEL_CFG0 = 3'b010;
  localparam logic [2:0] SEL_CFG1 = 3'b011;

  typedef enum logic [2:0] {
    ENG_IDLE,
    ENG_RX,
    ENG_ACK,
    ENG_TX,
    ENG_TXACK
  } eng_st_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_CMD,
    PH_DHI,
    PH_DLO
  } phase_e;

  function automatic logic sel_has_data(input logic [2:0] sel);
    return (sel == SEL_ADDR) || (sel == SEL_CFG0) || (sel == SEL_CFG1);
  endfunction

  function automatic logic [STB_N-1:0] cmd_strobes(input logic [7:0] c);
    logic [STB_N-1:0] v;
    v = '0;
    case ({c[6], c[5:3]})
      4'b0000: v[c[7] ? STB_PWR_UP : STB_PWR_DN]  = 1'b1;
      4'b0010: v[STB_REC]                         = 1'b1;
      4'b0001: v[STB_PLAY]                        = 1'b1;
      4'b1000: v[c[7] ? STB_DIG_IN : STB_DIG_OUT] = 1'b1;
      4'b1010: v[STB_ERASE]                       = 1'b1;
      4'b1001: v[STB_DWRITE]                      = 1'b1;
      4'b1100: v[STB_DREAD]                       = 1'b1;
      default: v = '0;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/i2cs_line_sync.sv
module i2cs_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);

  logic [STAGES-1:0] scl_pipe_q;
  logic [STAGES-1:0] sda_pipe_q;
  logic              scl_d_q;
  logic              sda_d_q;
  logic              scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe_q <= '1;
      sda_pipe_q <= '1;
      scl_d_q    <= 1'b1;
      sda_d_q    <= 1'b1;
    end else begin
      scl_pipe_q <= {scl_pipe_q[STAGES-2:0], scl_i};
      sda_pipe_q <= {sda_pipe_q[STAGES-2:0], sda_i};
      scl_d_q    <= scl_s;
      sda_d_q    <= sda_s;
    end
  end

  assign scl_s    = scl_pipe_q[STAGES-1];
  assign sda_s    = sda_pipe_q[STAGES-1];
  assign scl_rise = scl_s & ~scl_d_q;
  assign scl_fall = ~scl_s & scl_d_q;
  assign start_ev = scl_s & scl_d_q & sda_d_q & ~sda_s;
  assign stop_ev  = scl_s & scl_d_q & ~sda_d_q & sda_s;

endmodule

// File: rtl/i2cs_byte_engine.sv
module i2cs_byte_engine
  import i2cs_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic              sda_s,
  input  logic [ADDR_W-1:0] dev_addr,
  input  logic [BYTE_W-1:0] tx_byte,
  output logic              sda_oe,
  output logic              addr_hit,
  output logic              addr_rd,
  output logic              rx_valid,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              tx_load
);

  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);

  eng_st_e           st_q, st_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              oe_q, oe_d;
  logic              first_q, first_d;
  logic              rw_q, rw_d;
  logic              mack_q, mack_d;

  always_comb begin
    st_d     = st_q;
    sh_d     = sh_q;
    cnt_d    = cnt_q;
    oe_d     = oe_q;
    first_d  = first_q;
    rw_d     = rw_q;
    mack_d   = mack_q;
    addr_hit = 1'b0;
    rx_valid = 1'b0;
    tx_load  = 1'b0;
    if (start_ev) begin
      st_d    = ENG_RX;
      cnt_d   = '0;
      first_d = 1'b1;
      rw_d    = 1'b0;
      oe_d    = 1'b0;
    end else if (stop_ev) begin
      st_d = ENG_IDLE;
      oe_d = 1'b0;
    end else begin
      case (st_q)
        ENG_RX: begin
          if (scl_rise && cnt_q != CNT_FULL) begin
            sh_d  = {sh_q[BYTE_W-2:0], sda_s};
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == CNT_FULL) begin
            if (first_q) begin
              if (sh_q[BYTE_W-1:1] == dev_addr) begin
                addr_hit = 1'b1;
                rw_d     = sh_q[0];
                first_d  = 1'b0;
                oe_d     = 1'b1;
                st_d     = ENG_ACK;
              end else begin
                st_d = ENG_IDLE;
              end
            end else begin
              rx_valid = 1'b1;
              oe_d     = 1'b1;
              st_d     = ENG_ACK;
            end
          end
        end
        ENG_ACK: begin
          if (scl_fall) begin
            if (rw_q) begin
              tx_load = 1'b1;
              sh_d    = tx_byte;
              oe_d    = ~tx_byte[BYTE_W-1];
              cnt_d   = CNT_W'(1);
              st_d    = ENG_TX;
            end else begin
              oe_d  = 1'b0;
              cnt_d = '0;
              st_d  = ENG_RX;
            end
          end
        end
        ENG_TX: begin
          if (scl_fall) begin
            if (cnt_q == CNT_FULL) begin
              oe_d = 1'b0;
              st_d = ENG_TXACK;
            end else begin
              sh_d  = {sh_q[BYTE_W-2:0], 1'b0};
              oe_d  = ~sh_q[BYTE_W-2];
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        ENG_TXACK: begin
          if (scl_rise) begin
            mack_d = ~sda_s;
          end else if (scl_fall) begin
            if (mack_q) begin
              tx_load = 1'b1;
              sh_d    = tx_byte;
              oe_d    = ~tx_byte[BYTE_W-1];
              cnt_d   = CNT_W'(1);
              st_d    = ENG_TX;
            end else begin
              st_d = ENG_IDLE;
            end
          end
        end
        default: st_d = ENG_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ENG_IDLE;
      sh_q    <= '0;
      cnt_q   <= '0;
      oe_q    <= 1'b0;
      first_q <= 1'b0;
      rw_q    <= 1'b0;
      mack_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      sh_q    <= sh_d;
      cnt_q   <= cnt_d;
      oe_q    <= oe_d;
      first_q <= first_d;
      rw_q    <= rw_d;
      mack_q  <= mack_d;
    end
  end

  assign sda_oe  = oe_q;
  assign addr_rd = sh_q[0];
  assign rx_byte = sh_q;

  // R10: the slave only moves SDA after an SCL fall or a bus condition
  a_r10_oe_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_q != $past(oe_q)) |-> $past(scl_fall || start_ev || stop_ev));

  // R11: an idle engine never holds the line
  a_r11_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ENG_IDLE) |-> !oe_q);

endmodule

// File: rtl/i2cs_reg_file.sv
module i2cs_reg_file
  import i2cs_pkg::*;
#(
  parameter int REG_W  = 16,
  parameter int STAT_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_hit,
  input  logic              addr_rd,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              tx_load,
  input  logic              abort,
  input  logic              evt_i,
  input  logic [STAT_W-1:0] stat_i,
  output logic [BYTE_W-1:0] tx_byte,
  output logic [REG_W-1:0]  cfg0_q,
  output logic [REG_W-1:0]  cfg1_q,
  output logic [REG_W-1:0]  addr_q,
  output logic [STB_N-1:0]  cmd_stb,
  output logic              irq_o
);

  localparam int PTR_W = 2;
  localparam logic [PTR_W-1:0] PTR_END = '1;

  phase_e            ph_q, ph_d;
  logic [BYTE_W-1:0] cmd_q, cmd_d;
  logic [BYTE_W-1:0] hi_q, hi_d;
  logic [PTR_W-1:0]  ptr_q, ptr_d;
  logic [REG_W-1:0]  cfg0_d, cfg1_d, addr_d;
  logic [STB_N-1:0]  stb_q, stb_d;
  logic              irq_q, irq_d;
  logic [REG_W-1:0]  word;

  assign word = {hi_q, rx_byte};

  always_comb begin
    ph_d   = ph_q;
    cmd_d  = cmd_q;
    hi_d   = hi_q;
    ptr_d  = ptr_q;
    cfg0_d = cfg0_q;
    cfg1_d = cfg1_q;
    addr_d = addr_q;
    stb_d  = '0;
    if (abort) begin
      ph_d = PH_IDLE;
    end else if (addr_hit) begin
      ph_d  = addr_rd ? PH_IDLE : PH_CMD;
      ptr_d = '0;
    end else if (rx_valid) begin
      case (ph_q)
        PH_CMD: begin
          cmd_d = rx_byte;
          if (sel_has_data(rx_byte[2:0])) begin
            ph_d = PH_DHI;
          end else begin
            stb_d = cmd_strobes(rx_byte);
            ph_d  = PH_IDLE;
          end
        end
        PH_DHI: begin
          hi_d = rx_byte;
          ph_d = PH_DLO;
        end
        PH_DLO: begin
          case (cmd_q[2:0])
            SEL_ADDR: addr_d = word;
            SEL_CFG0: cfg0_d = word;
            SEL_CFG1: cfg1_d = word;
            default:  addr_d = addr_q;
          endcase
          stb_d = cmd_strobes(cmd_q);
          ph_d  = PH_IDLE;
        end
        default: ph_d = PH_IDLE;
      endcase
    end
    if (tx_load && ptr_q != PTR_END) begin
      ptr_d = ptr_q + 1'b1;
    end
    if (evt_i) begin
      irq_d = 1'b1;
    end else if (tx_load && ptr_q == '0) begin
      irq_d = 1'b0;
    end else begin
      irq_d = irq_q;
    end
  end

  always_comb begin
    case (ptr_q)
      2'd0:    tx_byte = {irq_q, stat_i};
      2'd1:    tx_byte = addr_q[REG_W-1 -: BYTE_W];
      2'd2:    tx_byte = addr_q[BYTE_W-1:0];
      default: tx_byte = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      cmd_q  <= '0;
      hi_q   <= '0;
      ptr_q  <= '0;
      cfg0_q <= '0;
      cfg1_q <= '0;
      addr_q <= '0;
      stb_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      cmd_q  <= cmd_d;
      hi_q   <= hi_d;
      ptr_q  <= ptr_d;
      cfg0_q <= cfg0_d;
      cfg1_q <= cfg1_d;
      addr_q <= addr_d;
      stb_q  <= stb_d;
      irq_q  <= irq_d;
    end
  end

  assign cmd_stb = stb_q;
  assign irq_o   = irq_q;

  // R12: never two strobes at once
  a_r12_stb_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(stb_q));

  // R5: a strobe always follows a received byte
  a_r5_stb_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (|stb_q) |-> $past(rx_valid));

  // R3 / R4: registers only move on the step after a received byte
  a_r3_regs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |=> ($stable(cfg0_q) && $stable(cfg1_q) && $stable(addr_q)));

  // R7: a bus condition never produces a strobe
  a_r7_abort_no_stb: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (stb_q == '0));

  // R9: an event leaves the interrupt pending even against a clear
  a_r9_evt_wins: assert property (@(posedge clk) disable iff (!rst_n)
    evt_i |=> irq_q);

endmodule

// File: rtl/i2cs_cmd_slave.sv
module i2cs_cmd_slave
  import i2cs_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [4:0] ADDR_HI     = 5'b10000,
  parameter int         REG_W       = 16,
  parameter int         PAGE_W      = 11
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe,
  input  logic [1:0]            strap_i,
  input  logic [BYTE_W-2:0]     stat_i,
  input  logic                  evt_i,
  output logic [STB_N-1:0]      cmd_stb,
  output logic [REG_W-1:0]      cfg0_o,
  output logic [REG_W-1:0]      cfg1_o,
  output logic [PAGE_W-1:0]     page_o,
  output logic [REG_W-PAGE_W-1:0] block_o,
  output logic                  irq_o
);

  localparam int ADDR_W = BYTE_W - 1;
  localparam int BLK_W  = REG_W - PAGE_W;

  logic [1:0]        rst_pipe_q;
  logic              rst_sync_n;
  logic              sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic              addr_hit, addr_rd, rx_valid, tx_load;
  logic [BYTE_W-1:0] rx_byte, tx_byte;
  logic [REG_W-1:0]  addr_q;
  logic [ADDR_W-1:0] dev_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe_q[1];

  assign dev_addr = {ADDR_HI, strap_i};

  i2cs_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev)
  );

  i2cs_byte_engine #(.ADDR_W(ADDR_W)) u_eng (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev),
    .sda_s    (sda_s),
    .dev_addr (dev_addr),
    .tx_byte  (tx_byte),
    .sda_oe   (sda_oe),
    .addr_hit (addr_hit),
    .addr_rd  (addr_rd),
    .rx_valid (rx_valid),
    .rx_byte  (rx_byte),
    .tx_load  (tx_load)
  );

  i2cs_reg_file #(.REG_W(REG_W), .STAT_W(ADDR_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .addr_hit (addr_hit),
    .addr_rd  (addr_rd),
    .rx_valid (rx_valid),
    .rx_byte  (rx_byte),
    .tx_load  (tx_load),
    .abort    (start_ev | stop_ev),
    .evt_i    (evt_i),
    .stat_i   (stat_i),
    .tx_byte  (tx_byte),
    .cfg0_q   (cfg0_o),
    .cfg1_q   (cfg1_o),
    .addr_q   (addr_q),
    .cmd_stb  (cmd_stb),
    .irq_o    (irq_o)
  );

  assign page_o  = addr_q[REG_W-1:BLK_W];
  assign block_o = addr_q[BLK_W-1:0];

endmodule

// File: tb/i2cs_cmd_slave_bench.sv
`timescale 1ns/1ps
module i2cs_cmd_slave_bench;

  localparam int Q = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        scl, sda_m;
  logic [1:0]  strap;
  logic [6:0]  stat;
  logic        evt;
  logic        sda_oe;
  logic [8:0]  cmd_stb;
  logic [15:0] cfg0, cfg1;
  logic [10:0] page;
  logic [4:0]  blk;
  logic        irq;
  logic        sda_line;

  int vectors = 0;
  int miscompares = 0;
  int multi_err = 0;
  int pulse_tot = 0;
  int pulse_bit [9];

  logic [15:0] m_cfg0, m_cfg1, m_addr;
  logic [7:0]  rd_q [4];

  always #2.5 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  i2cs_cmd_slave u_i2cs_cmd_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .strap_i(strap), .stat_i(stat), .evt_i(evt), .cmd_stb(cmd_stb),
    .cfg0_o(cfg0), .cfg1_o(cfg1), .page_o(page), .block_o(blk), .irq_o(irq)
  );

  // strobe monitor, R12 per cycle
  always @(negedge clk) begin
    if (cmd_stb != '0) begin
      pulse_tot <= pulse_tot + 1;
      if ($countones(cmd_stb) > 1) multi_err <= multi_err + 1;
      for (int i = 0; i < 9; i++) if (cmd_stb[i]) pulse_bit[i] <= pulse_bit[i] + 1;
    end
  end

  initial begin
    for (int i = 0; i < 9; i++) pulse_bit[i] = 0;
  end

  initial begin
    repeat (200000) @(posedge clk);
    $display("FAIL watchdog expired got running exp finished");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors + 1, miscompares + 1);
    $finish;
  end

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wt(Q); scl = 1'b1; wt(Q); sda_m = 1'b0; wt(Q); scl = 1'b0; wt(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wt(Q); scl = 1'b1; wt(Q); sda_m = 1'b1; wt(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wt(Q); scl = 1'b1; wt(Q); scl = 1'b0; wt(2);
    end
    sda_m = 1'b1; wt(Q); scl = 1'b1; wt(Q / 2);
    ack = ~sda_line;
    wt(Q / 2); scl = 1'b0; wt(2);
  endtask

  task automatic recv_byte(output logic [7:0] b, input logic nack);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wt(Q); scl = 1'b1; wt(Q / 2); b[i] = sda_line; wt(Q / 2); scl = 1'b0; wt(2);
    end
    sda_m = nack; wt(Q); scl = 1'b1; wt(Q); scl = 1'b0; wt(2); sda_m = 1'b1;
  endtask

  function automatic int exp_idx(input logic [7:0] c);
    case ({c[6], c[5:3]})
      4'b0000: return c[7] ? 0 : 1;
      4'b0010: return 2;
      4'b0001: return 3;
      4'b1000: return c[7] ? 4 : 5;
      4'b1010: return 6;
      4'b1001: return 7;
      4'b1100: return 8;
      default: return -1;
    endcase
  endfunction

  // model of one command with nd data bytes delivered before the STOP
  task automatic model_apply(input logic [7:0] c, input int nd, input logic [15:0] w,
                             output int idx);
    logic needs;
    needs = (c[2:0] == 3'b001) || (c[2:0] == 3'b010) || (c[2:0] == 3'b011);
    idx = -1;
    if (needs && nd < 2) return;
    if (needs) begin
      if (c[2:0] == 3'b001) m_addr = w;
      if (c[2:0] == 3'b010) m_cfg0 = w;
      if (c[2:0] == 3'b011) m_cfg1 = w;
    end
    idx = exp_idx(c);
  endtask

  task automatic check_state(input string tag, input int idx, input int tot0, input int b0);
    chk({tag, " strobe count"}, pulse_tot - tot0, (idx >= 0) ? 1 : 0);
    if (idx >= 0) chk({tag, " strobe bit"}, pulse_bit[idx] - b0, 1);
    chk({tag, " R3 cfg0"}, cfg0, m_cfg0);
    chk({tag, " R3 cfg1"}, cfg1, m_cfg1);
    chk({tag, " R4 page"}, page, m_addr[15:5]);
    chk({tag, " R4 block"}, blk, m_addr[4:0]);
  endtask

  task automatic do_write(input logic [7:0] sa, input logic [7:0] c, input int nd,
                          input logic [15:0] w, input string tag);
    logic ack;
    int   acks, tot0, b0, idx, pidx;
    acks = 0;
    tot0 = pulse_tot;
    pidx = exp_idx(c);
    b0   = (pidx >= 0) ? pulse_bit[pidx] : 0;
    bus_start();
    send_byte(sa, ack); acks += ack;
    send_byte(c, ack);  acks += ack;
    if (nd >= 1) begin send_byte(w[15:8], ack); acks += ack; end
    if (nd >= 2) begin send_byte(w[7:0], ack);  acks += ack; end
    bus_stop();
    wt(6);
    chk({tag, " R10 acks"}, acks, nd + 2);
    model_apply(c, nd, w, idx);
    check_state(tag, idx, tot0, b0);
  endtask

  task automatic do_read(input logic [7:0] sa, input int n, input string tag);
    logic ack;
    bus_start();
    send_byte(sa, ack);
    chk({tag, " R1 read address ack"}, ack, 1);
    for (int i = 0; i < n; i++) recv_byte(rd_q[i], i == n - 1);
    bus_stop();
    wt(6);
  endtask

  initial begin
    logic ack;
    int   tot0, b0;
    rst_n = 1'b0; scl = 1'b1; sda_m = 1'b1; strap = 2'b00; stat = 7'h15; evt = 1'b0;
    m_cfg0 = '0; m_cfg1 = '0; m_addr = '0;
    wt(10);
    rst_n = 1'b1;
    wt(10);

    // R11 reset state
    chk("R11 cfg0", cfg0, 0);
    chk("R11 cfg1", cfg1, 0);
    chk("R11 page/block", {page, blk}, 0);
    chk("R11 irq", irq, 0);
    chk("R11 sda released", sda_oe, 0);

    // R1 foreign address with strap 00
    tot0 = pulse_tot;
    bus_start(); send_byte(8'h82, ack); bus_stop(); wt(6);
    chk("R1 foreign address nack", ack, 0);
    chk("R1 foreign no strobe", pulse_tot - tot0, 0);

    // R3 configuration loads, R2 power-up strobe
    do_write(8'h80, 8'h82, 2, 16'hA53C, "R3 cfg0");
    do_write(8'h80, 8'h83, 2, 16'h12F0, "R3 cfg1");
    // R4 / R5 address with digital write
    do_write(8'h80, 8'hC9, 2, 16'h5A7F, "R4 write at address");
    // R2 single-byte commands
    do_write(8'h80, 8'h00, 0, 16'h0, "R2 power down");
    do_write(8'h80, 8'h90, 0, 16'h0, "R2 record");
    do_write(8'h80, 8'h88, 0, 16'h0, "R2 playback");
    do_write(8'h80, 8'hC0, 0, 16'h0, "R2 enter digital");
    do_write(8'h80, 8'h40, 0, 16'h0, "R2 exit digital");
    do_write(8'h80, 8'hF8, 0, 16'h0, "R2 undefined function");
    do_write(8'h80, 8'hE1, 2, 16'h0040, "R5 read at address");
    do_write(8'h80, 8'hD1, 2, 16'h1220, "R5 erase at address");
    do_write(8'h80, 8'h91, 2, 16'hFFE1, "R5 record at address");
    // R6 undefined select, data ignored
    do_write(8'h80, 8'h84, 2, 16'hFFFF, "R6 undefined select");
    do_write(8'h80, 8'h87, 2, 16'h1111, "R6 undefined select 7");
    // R7 partial command ended by STOP
    do_write(8'h80, 8'h82, 1, 16'h7700, "R7 stop after one byte");
    // R7 repeated start discards the first partial load
    tot0 = pulse_tot; b0 = pulse_bit[0];
    bus_start(); send_byte(8'h80, ack); send_byte(8'h83, ack); send_byte(8'h11, ack);
    bus_start(); send_byte(8'h80, ack); send_byte(8'h83, ack);
    send_byte(8'h22, ack); send_byte(8'h33, ack); bus_stop(); wt(6);
    m_cfg1 = 16'h2233;
    check_state("R7 repeated start", 0, tot0, b0);

    // R1 strap change
    strap = 2'b10;
    tot0 = pulse_tot;
    bus_start(); send_byte(8'h80, ack); bus_stop(); wt(6);
    chk("R1 old address now foreign", ack, 0);
    do_write(8'h84, 8'h83, 2, 16'h0001, "R1 strap 10");

    // R8 / R9 status read
    @(negedge clk); evt = 1'b1; @(negedge clk); evt = 1'b0; wt(2);
    chk("R9 event sets irq", irq, 1);
    do_read(8'h85, 4, "R8");
    chk("R8 status byte", rd_q[0], {1'b1, 7'h15});
    chk("R8 address high", rd_q[1], m_addr[15:8]);
    chk("R8 address low", rd_q[2], m_addr[7:0]);
    chk("R8 trailing byte", rd_q[3], 8'h00);
    chk("R9 status read clears irq", irq, 0);
    chk("R10 released after nack", sda_oe, 0);

    // R9 collision: event held across the status load
    stat = 7'h2A;
    evt = 1'b1;
    do_read(8'h85, 1, "R9 collision");
    evt = 1'b0; wt(2);
    chk("R9 status shows pending", rd_q[0], 8'hAA);
    chk("R9 event wins over clear", irq, 1);
    do_read(8'h85, 2, "R9 second read");
    chk("R9 second status", rd_q[0], 8'hAA);
    chk("R8 address high again", rd_q[1], m_addr[15:8]);
    chk("R9 cleared after second read", irq, 0);
    chk("R10 released after second nack", sda_oe, 0);

    // R10 bus still usable after a read
    do_write(8'h84, 8'h82, 2, 16'hBEEF, "R10 after read");

    chk("R12 single strobe per cycle", multi_err, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule